// File: doc/BRIEF.md
# DMA Control Byte Programming Port

This block is the side of a DMA controller that the processor programs. It accepts one byte per write cycle on a single byte-wide port. When no parameter bytes are outstanding, it classifies the byte as one of seven control registers. A control byte can do three things. It can set fields directly. It can announce that parameter bytes will follow, such as address halves, block length halves, a match value, a compare mask or a read mask. When it belongs to the command register, it can run a command.

Announced parameter bytes go into a small pending set and are filled in a fixed order. While any byte is pending, each write fills the next field and is never treated as a control byte. The block holds the register fields that the transfer engine uses. It also keeps the working address counters, the transferred-byte count and the match and end flags. The engine reports matches, block ends and transferred bytes through three pulse inputs. A status byte is presented combinationally for the processor to read.

Top module: `dma_prog_if`

## Requirements
- R1: Every write, whether a control byte or a parameter byte, leaves the enable output low afterwards. The only exceptions are a register-3 byte with bit 6 set, command 0x87 and command 0xD3.
- R2: Control bytes are classified as follows. With bit 7 clear: bits [1:0] non-zero selects register 0, otherwise bit 2 set selects register 1, otherwise register 2. With bit 7 set: bits [1:0] = 00 selects register 3, 01 selects register 4, 10 selects register 5 and 11 selects register 6 (the commands). A register-0 byte loads the command field from bits [1:0]. Its bits 3, 4, 5 and 6 announce, in that order, the low byte of the port A address, the high byte of the port A address, the low byte of the block length and the high byte of the block length.
- R3: A register-3 byte sets interrupt enable from bit 5 and enable from bit 6. Its bit 3 announces the compare-mask byte and its bit 4 announces the match-value byte.
- R4: A register-4 byte sets the mode from bits [6:5]. Its bit 2 announces the low byte of the port B address and its bit 3 announces the high byte. A register-5 byte stores bit 3 as the ready polarity.
- R5: Announced parameter bytes are filled in the field order A-low, A-high, length-low, length-high, mask, match, B-low, B-high, read mask. While any byte is pending, a write only fills the next field; it is not classified and runs no command.
- R6: Command 0x83 clears the enable bit and command 0x87 sets it.
- R7: The match_set and end_set inputs set the match flag and the end flag. Command 0x8B clears both flags. A clearing command wins over a set input that arrives in the same cycle.
- R8: Command 0xB3 copies the stored ready polarity into the ready output.
- R9: Command 0xC3 clears the command field, the enable bit and interrupt enable.
- R10: Command 0xCF does all of the following: reloads the mode from the last register-4 value, copies the port A and port B addresses into the working counters, zeroes the byte count, clears both flags and clears enable.
- R11: Each byte_inc pulse increments the byte count. Command 0xD3 zeroes the byte count, clears both flags and sets enable.
- R12: The status byte is built on 0xCC. Bit 0 is enable. Bit 1 is set when the mode is not 1 and ready differs from the stored polarity. Bit 4 is set while the match flag is clear and bit 5 is set while the end flag is clear.
- R13: After reset, ready is 1, the read mask is 0x38, and every other field, flag and counter is zero. Command 0xBB announces one read-mask parameter byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Processor write strobe, one byte per cycle |
| wr_data | input | 8 | Written byte |
| match_set | input | 1 | Engine reports a byte match |
| end_set | input | 1 | Engine reports block end |
| byte_inc | input | 1 | Engine reports one transferred byte |
| cmd | output | 2 | Command field |
| dma_en | output | 1 | DMA enable |
| mode | output | 2 | Transfer mode |
| irq_en | output | 1 | Interrupt enable |
| ready | output | 1 | Ready level (1 = inactive after reset) |
| rdy_pol | output | 1 | Stored ready polarity |
| addr_a | output | AW | Port A start address |
| addr_b | output | AW | Port B start address |
| blk_len | output | LW | Block length |
| match_val | output | 8 | Match value |
| mask_val | output | 8 | Compare mask |
| rd_mask | output | 8 | Read mask |
| cnt_a | output | AW | Port A working counter |
| cnt_b | output | AW | Port B working counter |
| byte_cnt | output | LW | Transferred-byte count |
| match_flag | output | 1 | Match flag |
| end_flag | output | 1 | End flag |
| status | output | 8 | Status byte |

## Verification
The bound checker checks, on every cycle, rules that hold for any sequence of writes:
- a parameter write consumes exactly one pending field;
- a parameter write leaves enable low;
- enable never rises without a write;
- a load command copies both start addresses into the counters;
- a flag-clearing command leaves both flags low;
- the fixed status bits stay set.

Only the directed scenarios can show that particular byte values decode to the intended fields. They also show that parameter bytes which look like commands are not run, the order in which queued fields are filled, and the exact status value in each combination of mode, polarity and flags.

// File: rtl/dmaprg_pkg.sv
package dmaprg_pkg;
  localparam int NFLD = 9;

  // parameter-byte destinations, in fill order
  typedef enum logic [3:0] {
    F_ALO, F_AHI, F_LLO, F_LHI, F_MASK, F_MATCH, F_BLO, F_BHI, F_RMASK
  } fld_e;

  typedef struct packed {
    logic off;
    logic on;
    logic clrflg;
    logic frdy;
    logic rst;
    logic load;
    logic cont;
  } cmdev_t;

  function automatic logic [2:0] classify(input logic [7:0] b);
    logic [2:0] r;
    if (!b[7]) begin
      if (b[1:0] != 2'b00) r = 3'd0;
      else if (b[2])       r = 3'd1;
      else                 r = 3'd2;
    end else begin
      case (b[1:0])
        2'b00:   r = 3'd3;
        2'b01:   r = 3'd4;
        2'b10:   r = 3'd5;
        default: r = 3'd6;
      endcase
    end
    return r;
  endfunction

  function automatic logic [NFLD-1:0] follow_mask(input logic [2:0] r, input logic [7:0] b);
    logic [NFLD-1:0] m;
    m = '0;
    case (r)
      3'd0: begin
        m[F_ALO] = b[3];
        m[F_AHI] = b[4];
        m[F_LLO] = b[5];
        m[F_LHI] = b[6];
      end
      3'd3: begin
        m[F_MASK]  = b[3];
        m[F_MATCH] = b[4];
      end
      3'd4: begin
        m[F_BLO] = b[2];
        m[F_BHI] = b[3];
      end
      3'd6: m[F_RMASK] = (b == 8'hBB);
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [3:0] first_pending(input logic [NFLD-1:0] p);
    logic [3:0] idx;
    idx = 4'd0;
    for (int i = NFLD - 1; i >= 0; i--) begin
      if (p[i]) idx = 4'(i);
    end
    return idx;
  endfunction

  function automatic logic [7:0] status_byte(input logic en, input logic [1:0] md,
                                             input logic pol, input logic rdy,
                                             input logic mf, input logic ef);
    logic [7:0] s;
    s    = 8'hCC;
    s[0] = en;
    s[1] = (md != 2'd1) && (pol != rdy);
    s[4] = !mf;
    s[5] = !ef;
    return s;
  endfunction
endpackage

// File: rtl/dmaprg_decode.sv
module dmaprg_decode
  import dmaprg_pkg::*;
(
  input  logic            base_wr,
  input  logic [7:0]      din,
  output logic [2:0]      sel,
  output logic [NFLD-1:0] qmask,
  output cmdev_t          ev
);
  always_comb begin
    sel   = classify(din);
    qmask = '0;
    ev    = '0;
    if (base_wr) begin
      qmask = follow_mask(sel, din);
      if (sel == 3'd6) begin
        case (din)
          8'h83: ev.off    = 1'b1;
          8'h87: ev.on     = 1'b1;
          8'h8B: ev.clrflg = 1'b1;
          8'hB3: ev.frdy   = 1'b1;
          8'hC3: ev.rst    = 1'b1;
          8'hCF: ev.load   = 1'b1;
          8'hD3: ev.cont   = 1'b1;
          default: ev = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmaprg_queue.sv
module dmaprg_queue
  import dmaprg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NFLD-1:0] load_mask,
  output logic            empty,
  output fld_e            cur,
  output logic [NFLD-1:0] pend
);
  assign empty = (pend == '0);
  assign cur   = fld_e'(first_pending(pend));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (wr_en) begin
      if (empty) pend <= load_mask;
      else       pend <= pend & ~(NFLD'(1) << cur);
    end
  end
endmodule

// File: rtl/dmaprg_status.sv
module dmaprg_status (
  input  logic       en,
  input  logic [1:0] md,
  input  logic       pol,
  input  logic       rdy,
  input  logic       mf,
  input  logic       ef,
  output logic [7:0] stat
);
  assign stat = dmaprg_pkg::status_byte(en, md, pol, rdy, mf, ef);
endmodule

// File: rtl/dma_prog_if.sv
module dma_prog_if
  import dmaprg_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          match_set,
  input  logic          end_set,
  input  logic          byte_inc,
  output logic [1:0]    cmd,
  output logic          dma_en,
  output logic [1:0]    mode,
  output logic          irq_en,
  output logic          ready,
  output logic          rdy_pol,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b,
  output logic [LW-1:0] blk_len,
  output logic [7:0]    match_val,
  output logic [7:0]    mask_val,
  output logic [7:0]    rd_mask,
  output logic [AW-1:0] cnt_a,
  output logic [AW-1:0] cnt_b,
  output logic [LW-1:0] byte_cnt,
  output logic          match_flag,
  output logic          end_flag,
  output logic [7:0]    status
);
  localparam int AHW = AW - 8;
  localparam int LHW = LW - 8;

  logic            q_empty;
  fld_e            q_cur;
  logic [NFLD-1:0] q_pend;
  logic [NFLD-1:0] q_load;
  logic [2:0]      reg_sel;
  cmdev_t          ev;
  logic            base_wr;
  logic            fld_wr;
  logic            ev_flagclr;
  logic [1:0]      wr4_mode;

  assign base_wr    = wr_en && q_empty;
  assign fld_wr     = wr_en && !q_empty;
  assign ev_flagclr = ev.clrflg || ev.load || ev.cont;

  dmaprg_decode u_dec (
    .base_wr (base_wr),
    .din     (wr_data),
    .sel     (reg_sel),
    .qmask   (q_load),
    .ev      (ev)
  );

  dmaprg_queue u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .load_mask (q_load),
    .empty     (q_empty),
    .cur       (q_cur),
    .pend      (q_pend)
  );

  dmaprg_status u_st (
    .en   (dma_en),
    .md   (mode),
    .pol  (rdy_pol),
    .rdy  (ready),
    .mf   (match_flag),
    .ef   (end_flag),
    .stat (status)
  );

  // control fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd      <= '0;
      dma_en   <= 1'b0;
      mode     <= '0;
      wr4_mode <= '0;
      irq_en   <= 1'b0;
      ready    <= 1'b1;
      rdy_pol  <= 1'b0;
    end else if (wr_en) begin
      dma_en <= 1'b0;
      if (base_wr) begin
        case (reg_sel)
          3'd0: cmd <= wr_data[1:0];
          3'd3: begin
            irq_en <= wr_data[5];
            dma_en <= wr_data[6];
          end
          3'd4: begin
            mode     <= wr_data[6:5];
            wr4_mode <= wr_data[6:5];
          end
          3'd5: rdy_pol <= wr_data[3];
          default: ;
        endcase
        if (ev.on || ev.cont) dma_en <= 1'b1;
        if (ev.frdy) ready <= rdy_pol;
        if (ev.load) mode <= wr4_mode;
        if (ev.rst) begin
          cmd    <= '0;
          irq_en <= 1'b0;
        end
      end
    end
  end

  // parameter bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_a    <= '0;
      addr_b    <= '0;
      blk_len   <= '0;
      match_val <= '0;
      mask_val  <= '0;
      rd_mask   <= 8'h38;
    end else if (fld_wr) begin
      case (q_cur)
        F_ALO:   addr_a[7:0]     <= wr_data;
        F_AHI:   addr_a[AW-1:8]  <= wr_data[AHW-1:0];
        F_LLO:   blk_len[7:0]    <= wr_data;
        F_LHI:   blk_len[LW-1:8] <= wr_data[LHW-1:0];
        F_MASK:  mask_val        <= wr_data;
        F_MATCH: match_val       <= wr_data;
        F_BLO:   addr_b[7:0]     <= wr_data;
        F_BHI:   addr_b[AW-1:8]  <= wr_data[AHW-1:0];
        default: rd_mask         <= wr_data;
      endcase
    end
  end

  // working counters and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a      <= '0;
      cnt_b      <= '0;
      byte_cnt   <= '0;
      match_flag <= 1'b0;
      end_flag   <= 1'b0;
    end else begin
      if (ev.load) begin
        cnt_a <= addr_a;
        cnt_b <= addr_b;
      end
      if (ev.load || ev.cont)  byte_cnt <= '0;
      else if (byte_inc)       byte_cnt <= byte_cnt + LW'(1);
      if (ev_flagclr) begin
        match_flag <= 1'b0;
        end_flag   <= 1'b0;
      end else begin
        if (match_set) match_flag <= 1'b1;
        if (end_set)   end_flag   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmaprg_chk.sv
module dmaprg_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          q_empty,
  input logic [8:0]    q_pend,
  input logic          ev_load,
  input logic          ev_flagclr,
  input logic [AW-1:0] addr_a,
  input logic [AW-1:0] addr_b,
  input logic [AW-1:0] cnt_a,
  input logic [AW-1:0] cnt_b,
  input logic          dma_en,
  input logic          match_flag,
  input logic          end_flag,
  input logic [7:0]    status
);
  p_param_consumes_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !q_empty) |=> ($countones(q_pend) == $countones($past(q_pend)) - 1));

  p_param_clears_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !q_empty) |=> !dma_en);

  p_en_needs_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_en) |-> $past(wr_en));

  p_load_copies_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> (cnt_a == $past(addr_a)) && (cnt_b == $past(addr_b)) && !dma_en);

  p_flags_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flagclr |=> (!match_flag && !end_flag));

  p_status_fixed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7:6] == 2'b11) && (status[3:2] == 2'b11)
    && (status[4] == !match_flag) && (status[5] == !end_flag));
endmodule

bind dma_prog_if dmaprg_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .q_empty    (q_empty),
  .q_pend     (q_pend),
  .ev_load    (ev.load),
  .ev_flagclr (ev_flagclr),
  .addr_a     (addr_a),
  .addr_b     (addr_b),
  .cnt_a      (cnt_a),
  .cnt_b      (cnt_b),
  .dma_en     (dma_en),
  .match_flag (match_flag),
  .end_flag   (end_flag),
  .status     (status)
);

// File: tb/tb_dma_prog_if.sv
`timescale 1ns/1ps
module tb_dma_prog_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        match_set = 1'b0, end_set = 1'b0, byte_inc = 1'b0;
  logic [1:0]  cmd, mode;
  logic        dma_en, irq_en, ready, rdy_pol, match_flag, end_flag;
  logic [15:0] addr_a, addr_b, blk_len, cnt_a, cnt_b, byte_cnt;
  logic [7:0]  match_val, mask_val, rd_mask, status;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dma_prog_if dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input bit m, input bit e, input bit inc);
    match_set = m; end_set = e; byte_inc = inc;
    @(negedge clk);
    match_set = 0; end_set = 0; byte_inc = 0;
  endtask

  task automatic t_reset;
    chk("R13 ready", ready, 1);
    chk("R13 rd_mask", rd_mask, 8'h38);
    chk("R13 en", dma_en, 0);
    chk("R13 addr_a", addr_a, 0);
    chk("R12 status reset", status, 8'hFE);
  endtask

  task automatic t_wr0;
    wr(8'h79);
    chk("R2 cmd", cmd, 1);
    wr(8'h87);
    chk("R5 param not a command", dma_en, 0);
    wr(8'h12);
    chk("R2 addr_a", addr_a, 16'h1287);
    wr(8'h05); wr(8'h00);
    chk("R2 blk_len", blk_len, 16'h0005);
    wr(8'h00);
    chk("R5 queue drained, reg2 ignored", addr_a, 16'h1287);
    chk("R5 cmd kept", cmd, 1);
  endtask

  task automatic t_wr3;
    wr(8'hD8);
    chk("R3 enable bit6", dma_en, 1);
    chk("R3 irq bit5 clear", irq_en, 0);
    wr(8'h0F);
    chk("R1 param write clears en", dma_en, 0);
    chk("R3 mask", mask_val, 8'h0F);
    wr(8'h42);
    chk("R3 match", match_val, 8'h42);
    wr(8'hA0);
    chk("R3 irq set", irq_en, 1);
  endtask

  task automatic t_wr4;
    wr(8'hAD);
    chk("R4 mode", mode, 1);
    wr(8'h34); wr(8'h12);
    chk("R4 addr_b", addr_b, 16'h1234);
    chk("R12 status mode1", status, 8'hFC);
  endtask

  task automatic t_ready;
    wr(8'h8A);
    chk("R4 polarity", rdy_pol, 1);
    wr(8'hC1);
    chk("R4 mode 2", mode, 2);
    chk("R12 pol matches ready", status, 8'hFC);
    wr(8'h82);
    chk("R12 pol differs", status, 8'hFE);
    wr(8'hB3);
    chk("R8 ready forced", ready, 0);
    chk("R12 after force", status, 8'hFC);
  endtask

  task automatic t_enable;
    wr(8'h87);
    chk("R6 enable", dma_en, 1);
    chk("R12 en bit", status, 8'hFD);
    wr(8'h83);
    chk("R6 disable", dma_en, 0);
    wr(8'h87); wr(8'h79);
    chk("R1 base write clears en", dma_en, 0);
    wr(8'h00); wr(8'h00); wr(8'h00); wr(8'h00);
    chk("R2 addr_a reloaded", addr_a, 16'h0000);
    wr(8'h79); wr(8'h87); wr(8'h12); wr(8'h05); wr(8'h00);
  endtask

  task automatic t_flags;
    pulse(1, 1, 0);
    chk("R7 match set", match_flag, 1);
    chk("R12 flags set", status, 8'hCC);
    wr(8'h8B);
    chk("R7 clear", {match_flag, end_flag}, 0);
    chk("R12 flags clear", status, 8'hFC);
    match_set = 1; end_set = 1;
    wr(8'h8B);
    match_set = 0; end_set = 0;
    chk("R7 clear wins", {match_flag, end_flag}, 0);
  endtask

  task automatic t_load;
    pulse(0, 0, 1); pulse(0, 0, 1); pulse(0, 1, 1);
    chk("R11 byte count", byte_cnt, 3);
    wr(8'h87);
    wr(8'hCF);
    chk("R10 cnt_a", cnt_a, 16'h1287);
    chk("R10 cnt_b", cnt_b, 16'h1234);
    chk("R10 count zero", byte_cnt, 0);
    chk("R10 en off", dma_en, 0);
    chk("R10 end clear", end_flag, 0);
    chk("R10 mode", mode, 2);
  endtask

  task automatic t_cont;
    pulse(0, 1, 1); pulse(1, 0, 1);
    wr(8'hD3);
    chk("R11 en", dma_en, 1);
    chk("R11 count", byte_cnt, 0);
    chk("R11 flags", {match_flag, end_flag}, 0);
  endtask

  task automatic t_rstcmd;
    wr(8'hC3);
    chk("R9 cmd", cmd, 0);
    chk("R9 en", dma_en, 0);
    chk("R9 irq", irq_en, 0);
  endtask

  task automatic t_rmask;
    wr(8'hBB);
    wr(8'h87);
    chk("R13 read mask filled", rd_mask, 8'h87);
    chk("R13 param not enable", dma_en, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wr0();
    t_wr3();
    t_wr4();
    t_ready();
    t_enable();
    t_flags();
    t_load();
    t_cont();
    t_rstcmd();
    t_rmask();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule